// File: doc/BRIEF.md
# Link Controller Power-Up and Reset Sequencer

This block brings a serial-link controller and its PHY out of power-down in a fixed, timed order. A one-cycle start command clears the PHY power-down, waits a short interval, and then turns on the reference clock. It then waits for the clocks to settle and pulses the reset line of the external endpoint. Next it releases the PHY reset. From there it either polls a PLL-lock status with a bounded number of retries or waits a fixed interval, depending on the build variant. Last, it releases the controller reset and pulses a done output.

A shutdown command returns every output to its power-on state. This gives a later start a clean starting point. A single strap input sets the polarity of the endpoint reset. Every interval is a count of microseconds. The core clock is divided into microsecond ticks by a prescaler whose ratio is a parameter, so a testbench can shrink all the delays.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, `phy_pd_o`=1, `refclk_en_o`=0, `phy_rst_o`=1, `ctrl_rst_o`=1, `busy_o`=0, `done_o`=0 and `timeout_o`=0. `ep_rst_o` sits at its asserted level. The asserted level is the value of `ep_rst_pol_i` (1 means active-high, so asserted drives 1).
- R2: A start accepted at a clock edge clears `phy_pd_o` in the next cycle. `refclk_en_o` rises exactly `PWRUP_US*TICK_CYC` cycles later.
- R3: `ep_rst_o` holds its asserted level from start until `(SETTLE_US+EP_PULSE_US)*TICK_CYC` cycles after the reference clock is enabled. It then goes to the deasserted level, which is the inverse of `ep_rst_pol_i`.
- R4: `phy_rst_o` is released in the same cycle that the endpoint reset is deasserted. The controller reset is never released while the PHY reset is held.
- R5: With the PLL-lock input present, lock is sampled every `LOCK_GAP_US*TICK_CYC` cycles after the PHY reset is released. The controller reset is released on the first sample that sees lock.
- R6: If `LOCK_TRIES` samples in a row see no lock, `timeout_o` rises `LOCK_TRIES*LOCK_GAP_US*TICK_CYC` cycles after the PHY release. At that point `busy_o` falls and `ctrl_rst_o` stays asserted.
- R7: `done_o` is a single-cycle pulse in the cycle that `ctrl_rst_o` falls. `busy_o` is high from the cycle after start until done or timeout.
- R8: A start that arrives while busy is ignored, and the sequence timing does not change.
- R9: A shutdown forces `phy_pd_o`=1, `refclk_en_o`=0, both PHY and controller resets asserted, the endpoint reset asserted, and `busy_o`=0 in the next cycle, from any state. A later start runs the whole sequence again.
- R10: In the variant without a PLL-lock input (`HAS_LOCK`=0), the controller reset is released a fixed `SWRST_US*TICK_CYC` cycles after the PHY release.
- R11: A new start clears a pending `timeout_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin bring-up (single cycle) |
| shutdown_i | input | 1 | Return everything to power-down |
| ep_rst_pol_i | input | 1 | 1: endpoint reset is active-high |
| pll_locked_i | input | 1 | PHY PLL lock status |
| phy_pd_o | output | 1 | PHY power-down |
| refclk_en_o | output | 1 | Reference clock enable |
| ep_rst_o | output | 1 | External endpoint reset line |
| phy_rst_o | output | 1 | PHY reset, active-high |
| ctrl_rst_o | output | 1 | Controller reset, active-high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the controller leaves reset |
| timeout_o | output | 1 | PLL lock never seen |

## Verification
Each step of the sequence ends on one prescaler tick, so a corrupt microsecond counter or a wrong state shows at the ports as an edge at the wrong cycle. The bench measures the gap between successive output edges to the exact cycle, so such a fault appears as soon as the step that follows it ends. A wrong retry count shows as a lock release or timeout one sample window early or late. A state that ignores shutdown leaves `refclk_en_o` or a reset wrong in the very next cycle.

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int TICK_CYC    = 100,
  parameter int PWRUP_US    = 10,
  parameter int SETTLE_US   = 200,
  parameter int EP_PULSE_US = 100,
  parameter int LOCK_GAP_US = 50,
  parameter int LOCK_TRIES  = 2000,
  parameter int SWRST_US    = 200,
  parameter bit HAS_LOCK    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic shutdown_i,
  input  logic ep_rst_pol_i,
  input  logic pll_locked_i,
  output logic phy_pd_o,
  output logic refclk_en_o,
  output logic ep_rst_o,
  output logic phy_rst_o,
  output logic ctrl_rst_o,
  output logic busy_o,
  output logic done_o,
  output logic timeout_o
);
  localparam int M1    = PWRUP_US > SETTLE_US ? PWRUP_US : SETTLE_US;
  localparam int M2    = EP_PULSE_US > LOCK_GAP_US ? EP_PULSE_US : LOCK_GAP_US;
  localparam int M3    = M1 > M2 ? M1 : M2;
  localparam int MAXUS = M3 > SWRST_US ? M3 : SWRST_US;
  localparam int US_W  = $clog2(MAXUS + 1);
  localparam int PRE_W = TICK_CYC > 1 ? $clog2(TICK_CYC) : 1;
  localparam int TRY_W = LOCK_TRIES > 1 ? $clog2(LOCK_TRIES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PWR, S_SETTLE, S_PULSE, S_POLL, S_RUN, S_FAIL} st_t;

  st_t              st;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us, win;
  logic [TRY_W-1:0] tries;
  logic             ep_asrt, tick, win_end;

  assign busy_o  = (st == S_PWR) || (st == S_SETTLE) || (st == S_PULSE) || (st == S_POLL);
  assign tick    = pre == PRE_W'(TICK_CYC - 1);
  assign win_end = busy_o && tick && (us == win - 1'b1);
  assign ep_rst_o = ep_asrt ? ep_rst_pol_i : ~ep_rst_pol_i;

  always_comb begin
    case (st)
      S_PWR:    win = US_W'(PWRUP_US);
      S_SETTLE: win = US_W'(SETTLE_US);
      S_PULSE:  win = US_W'(EP_PULSE_US);
      S_POLL:   win = HAS_LOCK ? US_W'(LOCK_GAP_US) : US_W'(SWRST_US);
      default:  win = US_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pre <= '0; us <= '0; tries <= '0;
      phy_pd_o <= 1'b1; refclk_en_o <= 1'b0; ep_asrt <= 1'b1;
      phy_rst_o <= 1'b1; ctrl_rst_o <= 1'b1; done_o <= 1'b0; timeout_o <= 1'b0;
    end else if (shutdown_i) begin
      st <= S_IDLE; pre <= '0; us <= '0; tries <= '0;
      phy_pd_o <= 1'b1; refclk_en_o <= 1'b0; ep_asrt <= 1'b1;
      phy_rst_o <= 1'b1; ctrl_rst_o <= 1'b1; done_o <= 1'b0; timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (win_end || !busy_o) begin
        pre <= '0; us <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) us <= us + 1'b1;
      end
      case (st)
        S_PWR: if (win_end) begin
          refclk_en_o <= 1'b1; st <= S_SETTLE;
        end
        S_SETTLE: if (win_end) st <= S_PULSE;
        S_PULSE: if (win_end) begin
          ep_asrt <= 1'b0; phy_rst_o <= 1'b0; tries <= '0; st <= S_POLL;
        end
        S_POLL: if (win_end) begin
          if (!HAS_LOCK || pll_locked_i) begin
            ctrl_rst_o <= 1'b0; done_o <= 1'b1; st <= S_RUN;
          end else if (tries == TRY_W'(LOCK_TRIES - 1)) begin
            timeout_o <= 1'b1; st <= S_FAIL;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        default: if (start_i) begin
          st <= S_PWR; phy_pd_o <= 1'b0; refclk_en_o <= 1'b0; ep_asrt <= 1'b1;
          phy_rst_o <= 1'b1; ctrl_rst_o <= 1'b1; timeout_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

module link_bringup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic shutdown_i,
  input logic ep_rst_pol_i,
  input logic phy_pd_o,
  input logic refclk_en_o,
  input logic ep_rst_o,
  input logic phy_rst_o,
  input logic ctrl_rst_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);
  p_refclk_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_en_o |-> !phy_pd_o);
  p_ep_released_with_phy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_o |-> (ep_rst_o == !ep_rst_pol_i));
  p_ctrl_after_phy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rst_o |-> !phy_rst_o);
  p_timeout_holds_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (ctrl_rst_o && !busy_o));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_on_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ctrl_rst_o && $past(ctrl_rst_o)));
  p_shutdown_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (phy_pd_o && !refclk_en_o && phy_rst_o && ctrl_rst_o && !busy_o));
endmodule

bind link_bringup_seq link_bringup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i), .ep_rst_pol_i(ep_rst_pol_i),
  .phy_pd_o(phy_pd_o), .refclk_en_o(refclk_en_o), .ep_rst_o(ep_rst_o),
  .phy_rst_o(phy_rst_o), .ctrl_rst_o(ctrl_rst_o), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/link_bringup_seq_tb_top.sv
module link_bringup_seq_tb_top;
  localparam int TC = 4, PW = 3, ST = 5, EP = 2, GAP = 2, TR = 4, SW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sd = 1'b0, pol = 1'b1, lock = 1'b0;
  logic pd, ref_en, ep, phy, ctrl, busy, done, tmo;
  logic pd2, ref2, ep2, phy2, ctrl2, busy2, done2, tmo2;
  int cyc = 0, tests = 0, fails = 0;

  always #10 clk = ~clk;

  link_bringup_seq #(.TICK_CYC(TC), .PWRUP_US(PW), .SETTLE_US(ST), .EP_PULSE_US(EP),
    .LOCK_GAP_US(GAP), .LOCK_TRIES(TR), .SWRST_US(SW), .HAS_LOCK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(sd), .ep_rst_pol_i(pol),
    .pll_locked_i(lock), .phy_pd_o(pd), .refclk_en_o(ref_en), .ep_rst_o(ep),
    .phy_rst_o(phy), .ctrl_rst_o(ctrl), .busy_o(busy), .done_o(done), .timeout_o(tmo));

  link_bringup_seq #(.TICK_CYC(TC), .PWRUP_US(PW), .SETTLE_US(ST), .EP_PULSE_US(EP),
    .LOCK_GAP_US(GAP), .LOCK_TRIES(TR), .SWRST_US(SW), .HAS_LOCK(1'b0)) dut_nl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(sd), .ep_rst_pol_i(pol),
    .pll_locked_i(1'b0), .phy_pd_o(pd2), .refclk_en_o(ref2), .ep_rst_o(ep2),
    .phy_rst_o(phy2), .ctrl_rst_o(ctrl2), .busy_o(busy2), .done_o(done2), .timeout_o(tmo2));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {poke_while_busy, polarity, lock sample index (15 = never)}
  localparam logic [5:0] VEC [6] = '{6'b0_1_0000, 6'b0_0_0000, 6'b1_1_0010,
                                     6'b0_0_0011, 6'b0_0_0001, 6'b0_1_1111};

  task automatic run_vec(bit poke, bit p, int k);
    int t0, tpd, tref, tep, tphy, tctrl, tdone, ttmo, tphy2, tctrl2, dones, busy_ref, tmo_pd;
    pol = p; lock = 1'b0;
    @(negedge clk) sd = 1'b1;
    @(negedge clk) sd = 1'b0;
    @(negedge clk);
    chk("R9 pd", pd, 1); chk("R9 refclk", ref_en, 0); chk("R9 phy_rst", phy, 1);
    chk("R9 ctrl_rst", ctrl, 1); chk("R9 busy", busy, 0); chk("R9 ep level", ep, p);
    start = 1'b1; t0 = cyc;
    tpd = -1; tref = -1; tep = -1; tphy = -1; tctrl = -1; tdone = -1; ttmo = -1;
    tphy2 = -1; tctrl2 = -1; dones = 0; busy_ref = 0; tmo_pd = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      start = (poke && i == 20);
      if (tpd < 0 && !pd) begin tpd = cyc; tmo_pd = tmo; end
      if (tref < 0 && ref_en) begin tref = cyc; busy_ref = busy; end
      if (tep < 0 && ep != p) tep = cyc;
      if (tphy < 0 && !phy) tphy = cyc;
      if (tctrl < 0 && !ctrl) tctrl = cyc;
      if (done) begin dones++; if (tdone < 0) tdone = cyc; end
      if (ttmo < 0 && tmo) ttmo = cyc;
      if (tphy2 < 0 && !phy2) tphy2 = cyc;
      if (tctrl2 < 0 && !ctrl2) tctrl2 = cyc;
      lock = (tphy >= 0) && (k < 15) && (cyc - tphy >= 8 * k + 4);
    end
    chk("R2 pd falls", tpd - t0, 1);
    chk("R2 refclk delay", tref - tpd, PW * TC);
    chk("R3 ep pulse", tep - tref, (ST + EP) * TC);
    chk("R4 phy with ep", tphy - tep, 0);
    chk("R7 busy mid", busy_ref, 1);
    chk("R11 timeout clear at start", tmo_pd, 0);
    chk("R10 fixed delay", tctrl2 - tphy2, SW * TC);
    chk("R8 R5 no early release", (poke && k < TR) ? tctrl - tphy : (k + 1) * GAP * TC,
        (k + 1) * GAP * TC);
    if (k < TR) begin
      chk("R5 lock release", tctrl - tphy, (k + 1) * GAP * TC);
      chk("R7 done once", dones, 1);
      chk("R7 done cycle", tdone - tctrl, 0);
      chk("R7 busy end", busy, 0);
      chk("R6 no timeout", tmo, 0);
    end else begin
      chk("R6 timeout time", ttmo - tphy, TR * GAP * TC);
      chk("R6 ctrl held", ctrl, 1);
      chk("R6 busy low", busy, 0);
      chk("R7 no done", dones, 0);
    end
  endtask

  initial begin
    pol = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pd", pd, 1); chk("R1 refclk", ref_en, 0); chk("R1 phy_rst", phy, 1);
    chk("R1 ctrl_rst", ctrl, 1); chk("R1 ep asserted", ep, 1); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0); chk("R1 timeout", tmo, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 6; v++) run_vec(VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
    // R11: restart straight from timeout
    chk("R11 timeout pending", tmo, 1);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R11 timeout cleared", tmo, 0);
    chk("R11 busy again", busy, 1);
    // R9: shutdown in the middle of the sequence
    repeat (20) @(negedge clk);
    chk("R9 refclk on before sd", ref_en, 1);
    sd = 1'b1;
    @(negedge clk) sd = 1'b0;
    chk("R9 mid pd", pd, 1); chk("R9 mid refclk", ref_en, 0);
    chk("R9 mid busy", busy, 0); chk("R9 mid ep", ep, 1);
    run_vec(1'b0, 1'b1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule